// File: doc/BRIEF.md
# Glitch-Free Clock Source Switch Controller

This block selects one of several free-running input clocks and drives it onto a single output clock. A change of source is never applied at once. The controller first stops the output low on the old source, in that source's own clock domain. It waits until that stop is confirmed. It then releases the output on the new source, again in the new source's own domain. Because of this sequence the output never carries a shortened high or low phase.

Software drives the block through a two-word register port. The control word holds the wanted source, a switch trigger bit and a safe-clock request bit. Both request bits clear themselves when the hardware takes the request. The status word reports the lane that is currently selected, a busy flag that covers the whole handshake, a flag showing that the safe clock is in use, and a two-bit code telling how the last request ended. The safe clock is an always-on fallback. It is modelled as an extra lane with an index one above the last ordinary source, and a liveness input tells the controller whether it is running.

Top module: `clk_src_switch`

## Requirements
- R1: After reset, the status word reads 0x00 (lane 0, not busy, safe flag clear, code 0 = success), the control word reads 0x00, and the output follows source 0.
- R2: The control word keeps the select field in bits [2:0], the trigger in bit 4 and the safe request in bit 5. Once a request is taken, both request bits read back 0 while the select field keeps the value written.
- R3: The busy flag, status bit 4, is set from the cycle after a request is taken until the new source drives the output.
- R4: When an ordinary switch completes, the status select field (bits [2:0]) equals the requested source, the code field (bits [7:6]) reads 0, and the output runs at the new source's period.
- R5: A safe request moves the output to the safe clock. Once done, the status select field reads N_SRC, the safe flag (bit 5) reads 1 and the code reads 1.
- R6: A safe request made while the liveness input is low still stops the old source. It then completes without waiting, with code 2 and the safe flag set. The output stays low until the safe clock runs again, and then it carries that clock.
- R7: A write to the control word while a request is pending or busy is ignored: the select field is unchanged and the trigger stays 0.
- R8: A trigger with a select value of N_SRC or above is rejected without a switch. The code becomes 3, busy stays clear and the output is unchanged.
- R9: No high or low phase of the output is shorter than the shortest half period of any input clock.
- R10: When the trigger and the safe request are set in the same write, the safe request wins.
- R11: An ordinary switch away from the safe clock clears the safe flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and controller clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Word select: 0 = control, 1 = status |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| src_clk | input | N_SRC | Ordinary source clocks |
| safe_clk | input | 1 | Always-on fallback clock |
| safe_alive | input | 1 | High while the fallback clock is running |
| clk_out | output | 1 | Selected output clock |

## Verification
A wrong lane index or a lost enable shows on the output as the wrong period, or as no clock at all. This is visible on the first two rising edges after busy drops. A handshake that releases the new lane before the old one has stopped shows as a short phase on the output, and the bench measures every edge to catch it. A controller that hangs keeps the busy flag set, and the poll loop sees this within a few hundred cycles. A faulty trigger or ignore path shows in the control word on the read that follows the write.

// File: rtl/ccs_pkg.sv
`timescale 1ns/1ps
package ccs_pkg;

  // control word layout
  localparam int CTL_GO_BIT   = 4;
  localparam int CTL_SAFE_BIT = 5;
  // status word layout
  localparam int ST_BUSY_BIT  = 4;
  localparam int ST_SAFE_BIT  = 5;
  localparam int ST_CAUSE_LSB = 6;

  localparam logic ADDR_CTL = 1'b0;
  localparam logic ADDR_ST  = 1'b1;

  typedef enum logic [1:0] {
    CAUSE_OK        = 2'd0,
    CAUSE_SAFE      = 2'd1,
    CAUSE_SAFE_DEAD = 2'd2,
    CAUSE_BAD_SEL   = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_DROP  = 2'd1,
    SW_RAISE = 2'd2
  } sw_state_e;

endpackage

// File: rtl/ccs_sync.sv
`timescale 1ns/1ps
module ccs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/ccs_chan_gate.sv
`timescale 1ns/1ps
module ccs_chan_gate (
  input  logic clk_ch,
  input  logic rst,
  input  logic en_req_i,
  output logic gate_o
);
  logic s1_q, s2_q;

  // request brought into the lane's own domain
  always_ff @(posedge clk_ch) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= en_req_i;
      s2_q <= s1_q;
    end
  end

  // gate changes only while the lane clock is low
  always_ff @(negedge clk_ch) begin
    if (rst) gate_o <= 1'b0;
    else     gate_o <= s2_q;
  end
endmodule

// File: rtl/ccs_regfile.sv
`timescale 1ns/1ps
module ccs_regfile
  import ccs_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              take_i,
  input  logic [SEL_W-1:0]  cur_i,
  input  logic              safe_on_i,
  input  cause_e            cause_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              go_o,
  output logic              safe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_valid_o
);
  localparam logic [DATA_W-1:0] USED_MASK =
    DATA_W'((1 << SEL_W) - 1) | DATA_W'(1 << CTL_GO_BIT) | DATA_W'(1 << CTL_SAFE_BIT);

  logic              blocked;
  logic              ctl_wr;
  logic [DATA_W-1:0] ctl_word;
  logic [DATA_W-1:0] st_word;
  logic              unused_wbits;

  assign blocked      = busy_i | take_i;
  assign ctl_wr       = wr_en_i && (addr_i == ADDR_CTL) && !blocked;
  assign unused_wbits = ^(wdata_i & ~USED_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o  <= '0;
      go_o   <= 1'b0;
      safe_o <= 1'b0;
    end else if (ctl_wr) begin
      sel_o  <= wdata_i[SEL_W-1:0];
      go_o   <= wdata_i[CTL_GO_BIT];
      safe_o <= wdata_i[CTL_SAFE_BIT];
    end else if (take_i) begin
      go_o   <= 1'b0;
      safe_o <= 1'b0;
    end
  end

  always_comb begin
    ctl_word = '0;
    ctl_word[SEL_W-1:0]   = sel_o;
    ctl_word[CTL_GO_BIT]   = go_o;
    ctl_word[CTL_SAFE_BIT] = safe_o;
    st_word = '0;
    st_word[SEL_W-1:0]                   = cur_i;
    st_word[ST_BUSY_BIT]                 = busy_i;
    st_word[ST_SAFE_BIT]                 = safe_on_i;
    st_word[ST_CAUSE_LSB+1:ST_CAUSE_LSB] = cause_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o    <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= (addr_i == ADDR_ST) ? st_word : ctl_word;
    end
  end

  // R2
  trig_clear_chk: assert property (@(posedge clk) disable iff (rst)
    take_i |=> (!go_o && !safe_o));

  // R7
  busy_wr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_i && wr_en_i) |=> ($stable(sel_o) && !go_o));
endmodule

// File: rtl/ccs_switch_fsm.sv
`timescale 1ns/1ps
module ccs_switch_fsm
  import ccs_pkg::*;
#(
  parameter int N_SRC = 4,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_i,
  input  logic             safe_req_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             safe_alive_i,
  input  logic [N_SRC:0]   ack_i,
  output logic [N_SRC:0]   en_req_o,
  output logic             take_o,
  output logic             busy_o,
  output logic             safe_on_o,
  output cause_e           cause_o,
  output logic [SEL_W-1:0] cur_o
);
  localparam logic [SEL_W-1:0] SAFE_IDX = SEL_W'(N_SRC);

  sw_state_e        state_q;
  logic [SEL_W-1:0] tgt_q;
  logic             tgt_safe_q;
  logic             ack_cur;

  assign ack_cur = ack_i[cur_o];
  assign take_o  = (state_q == SW_IDLE) && (go_i || safe_req_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SW_IDLE;
      tgt_q      <= '0;
      tgt_safe_q <= 1'b0;
      cur_o      <= '0;
      en_req_o   <= {{N_SRC{1'b0}}, 1'b1};
      busy_o     <= 1'b0;
      safe_on_o  <= 1'b0;
      cause_o    <= CAUSE_OK;
    end else begin
      unique case (state_q)
        SW_IDLE: begin
          if (safe_req_i) begin
            tgt_q           <= SAFE_IDX;
            tgt_safe_q      <= 1'b1;
            en_req_o[cur_o] <= 1'b0;
            busy_o          <= 1'b1;
            state_q         <= SW_DROP;
          end else if (go_i) begin
            if (sel_i >= SAFE_IDX) begin
              cause_o <= CAUSE_BAD_SEL;
            end else begin
              tgt_q           <= sel_i;
              tgt_safe_q      <= 1'b0;
              en_req_o[cur_o] <= 1'b0;
              busy_o          <= 1'b1;
              state_q         <= SW_DROP;
            end
          end
        end
        SW_DROP: begin
          if (!ack_cur) begin
            cur_o           <= tgt_q;
            en_req_o[tgt_q] <= 1'b1;
            if (tgt_safe_q && !safe_alive_i) begin
              busy_o    <= 1'b0;
              safe_on_o <= 1'b1;
              cause_o   <= CAUSE_SAFE_DEAD;
              state_q   <= SW_IDLE;
            end else begin
              state_q <= SW_RAISE;
            end
          end
        end
        SW_RAISE: begin
          if (ack_cur) begin
            busy_o    <= 1'b0;
            safe_on_o <= tgt_safe_q;
            cause_o   <= tgt_safe_q ? CAUSE_SAFE : CAUSE_OK;
            state_q   <= SW_IDLE;
          end
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  // R3
  busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != SW_IDLE) |-> busy_o);

  // R4
  done_lane_live_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_o) && (cause_o != CAUSE_SAFE_DEAD)) |-> ack_i[cur_o]);

  // R5
  safe_flag_lane_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(safe_on_o) |-> (cur_o == SAFE_IDX));

  // R8
  bad_sel_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (take_o && !safe_req_i && (sel_i >= SAFE_IDX)) |=> (!busy_o && cause_o == CAUSE_BAD_SEL));
endmodule

// File: rtl/clk_src_switch.sv
`timescale 1ns/1ps
module clk_src_switch
  import ccs_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid,
  input  logic [N_SRC-1:0]  src_clk,
  input  logic              safe_clk,
  input  logic              safe_alive,
  output logic              clk_out
);
  localparam int NCH   = N_SRC + 1;
  localparam int SEL_W = $clog2(NCH);

  logic [NCH-1:0]   lane_clk;
  logic [NCH-1:0]   en_req;
  logic [NCH-1:0]   gate;
  logic [NCH-1:0]   ack;
  logic             alive_s;
  logic [SEL_W-1:0] sel, cur;
  logic             go, safe_req, take, busy, safe_on;
  cause_e           cause;

  assign lane_clk = {safe_clk, src_clk};

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    ccs_chan_gate u_gate (
      .clk_ch   (lane_clk[g]),
      .rst      (rst),
      .en_req_i (en_req[g]),
      .gate_o   (gate[g])
    );
  end

  ccs_sync #(.W(NCH)) u_ack_sync (
    .clk (clk), .rst (rst), .d_i (gate), .q_o (ack)
  );

  ccs_sync #(.W(1)) u_alive_sync (
    .clk (clk), .rst (rst), .d_i (safe_alive), .q_o (alive_s)
  );

  ccs_regfile #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .busy_i     (busy),
    .take_i     (take),
    .cur_i      (cur),
    .safe_on_i  (safe_on),
    .cause_i    (cause),
    .sel_o      (sel),
    .go_o       (go),
    .safe_o     (safe_req),
    .rdata_o    (rdata),
    .rd_valid_o (rd_valid)
  );

  ccs_switch_fsm #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .go_i         (go),
    .safe_req_i   (safe_req),
    .sel_i        (sel),
    .safe_alive_i (alive_s),
    .ack_i        (ack),
    .en_req_o     (en_req),
    .take_o       (take),
    .busy_o       (busy),
    .safe_on_o    (safe_on),
    .cause_o      (cause),
    .cur_o        (cur)
  );

  assign clk_out = |(lane_clk & gate);

  // R9
  lane_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack));
endmodule

// File: tb/sim_clk_src_switch.sv
`timescale 1ns/1ps
module sim_clk_src_switch;
  localparam int N_SRC  = 4;
  localparam int DATA_W = 8;

  typedef struct {
    logic [7:0] exp;
    logic [7:0] mask;
    string      tag;
  } sb_item_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              rd_valid;
  logic [N_SRC-1:0]  src_clk = '0;
  logic              safe_clk = 1'b0;
  logic              safe_run = 1'b1;
  logic              clk_out;

  int checks = 0;
  int errors = 0;
  int runts = 0;
  int edges = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;
  realtime last_edge = 0;
  sb_item_t sbq[$];

  clk_src_switch #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u0 (
    .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en), .addr (addr),
    .wdata (wdata), .rdata (rdata), .rd_valid (rd_valid), .src_clk (src_clk),
    .safe_clk (safe_clk), .safe_alive (safe_run), .clk_out (clk_out)
  );

  always #5  clk = ~clk;
  always #7  src_clk[0] = ~src_clk[0];
  always #9  src_clk[1] = ~src_clk[1];
  always #11 src_clk[2] = ~src_clk[2];
  always #13 src_clk[3] = ~src_clk[3];
  initial forever begin
    #20;
    safe_clk = safe_run ? ~safe_clk : 1'b0;
  end

  // phase-width monitor on the output (R9)
  always @(clk_out) begin
    edges++;
    if (mon_en && ($realtime - last_edge) < 6.99) runts++;
    last_edge = $realtime;
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rd_valid && sbq.size() > 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      checks++;
      if ((rdata & it.mask) !== (it.exp & it.mask)) begin
        errors++;
        $display("FAIL %s: got 0x%02h expected 0x%02h (mask 0x%02h)",
                 it.tag, rdata, it.exp, it.mask);
      end
    end
  end

  task automatic check_val(input bit ok, input string tag, input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0.2f expected %0.2f", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic a, input logic [7:0] e, input logic [7:0] m, input string tag);
    sb_item_t it;
    @(negedge clk);
    it.exp = e; it.mask = m; it.tag = tag;
    sbq.push_back(it);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_raw(input logic a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 500; i++) begin
      rd_raw(1'b1, v);
      if (!v[4]) break;
    end
  endtask

  task automatic period_is(input real exp, input string tag);
    realtime t0, t1;
    @(posedge clk_out);
    @(posedge clk_out); t0 = $realtime;
    @(posedge clk_out); t1 = $realtime;
    check_val(((t1 - t0) > exp - 0.01) && ((t1 - t0) < exp + 0.01), tag, t1 - t0, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int e0;
    repeat (10) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    repeat (20) @(posedge clk);
    mon_en = 1'b1;

    // R1 reset state
    rd_expect(1'b1, 8'h00, 8'hFF, "R1 status after reset");
    rd_expect(1'b0, 8'h00, 8'hFF, "R1 control after reset");
    period_is(14.0, "R1 output on source 0");

    // R2/R3/R7: switch to 2, second write while pending/busy ignored
    wr(1'b0, 8'h12);
    wr(1'b0, 8'h11);
    rd_expect(1'b1, 8'h10, 8'h10, "R3 busy during switch");
    rd_expect(1'b0, 8'h02, 8'hFF, "R2 R7 trigger cleared, select kept");
    wait_idle();
    rd_expect(1'b1, 8'h02, 8'hFF, "R4 status after switch to 2");
    period_is(22.0, "R4 output on source 2");

    // R8 out-of-range select
    wr(1'b0, 8'h16);
    repeat (5) @(posedge clk);
    rd_expect(1'b1, 8'hC2, 8'hFF, "R8 bad select rejected");
    period_is(22.0, "R8 output unchanged");

    // R4 second pattern
    wr(1'b0, 8'h11);
    wait_idle();
    rd_expect(1'b1, 8'h01, 8'hFF, "R4 status after switch to 1");
    period_is(18.0, "R4 output on source 1");

    // R5/R10 safe and trigger together
    wr(1'b0, 8'h33);
    wait_idle();
    rd_expect(1'b1, 8'h64, 8'hFF, "R5 R10 safe clock status");
    rd_expect(1'b0, 8'h03, 8'hFF, "R10 both triggers cleared");
    period_is(40.0, "R5 output on safe clock");

    // R11 leave safe clock
    wr(1'b0, 8'h13);
    wait_idle();
    rd_expect(1'b1, 8'h03, 8'hFF, "R11 safe flag cleared");
    period_is(26.0, "R11 output on source 3");

    // R6 safe request with dead safe clock
    safe_run = 1'b0;
    #100;
    wr(1'b0, 8'h20);
    wait_idle();
    rd_expect(1'b1, 8'hA4, 8'hFF, "R6 dead safe status");
    #100;
    e0 = edges;
    #300;
    check_val(edges == e0, "R6 output held low", real'(edges - e0), 0.0);
    safe_run = 1'b1;
    #400;
    period_is(40.0, "R6 output after safe clock resumes");

    // back to source 0
    wr(1'b0, 8'h10);
    wait_idle();
    rd_expect(1'b1, 8'h00, 8'hFF, "R4 R11 status after switch to 0");
    period_is(14.0, "R4 output on source 0");

    repeat (4) @(posedge clk);
    check_val(runts == 0, "R9 no short output phase", real'(runts), 0.0);
    finish_run();
  end
endmodule